// File: doc/BRIEF.md
# Rotating Twenty-Lane Byte Distributor

This block sits on the transmit side of a multi-lane optical transport interface. It takes one frame-aligned byte per cycle, marked by a start-of-frame flag, and deals the frame out to 20 logical lanes in 16-byte blocks, one lane after another in round-robin order. Before distribution, it overwrites two overhead bytes in the frame header. One carries a per-frame lane marker that counts 0 to 239. The other carries an 8-bit multiframe counter.

The lane that receives the first block of a frame is the lane marker modulo 20. The assignment therefore shifts by one lane on every frame. A receiver can name each lane from the marker it finds there, and can measure skew across up to 240 frames. Both counters start at zero together, so a zero marker and a zero multiframe value coincide once every 3840 frames. The frame length is a parameter and must be a multiple of 320, so that short frames can be used in simulation. The marker count must be a multiple of the lane count.

Top module: `rld_lane_distributor`

## Requirements
- R1: A byte accepted on cycle t appears on exactly one lane at the clock edge that ends cycle t. `lane_vld[l]` is high for that cycle and `lane_data[8l+7:8l]` holds the byte. No more than one `lane_vld` bit is ever high.
- R2: Zero-based frame byte p belongs to block b = p/16. Block b goes to lane (k + b) mod 20, where k is the current lane marker mod 20. The mapping repeats every 320 bytes across the whole frame.
- R3: The lane marker is 0 after reset. It increases by one after each completed frame and wraps from 239 to 0.
- R4: Zero-based frame byte 5 is replaced on its lane by the current lane marker value.
- R5: The multiframe counter is 0 after reset and increases by one after each completed frame, wrapping from 255 to 0. Its value replaces zero-based frame byte 6. Because both counters start together, marker 0 meets multiframe value 0 every 3840 frames.
- R6: In a cycle with `in_valid` low, no byte is accepted and `in_sof` is ignored. Every `lane_vld` bit is low on the next cycle, lane data holds, and the byte position does not move.
- R7: After reset, and after the last byte of a frame, bytes offered without `in_sof` are dropped and strobe no lane. A byte with `in_valid` and `in_sof` high starts a frame at position 0.
- R8: An `in_sof` that arrives in the middle of a frame restarts the position at 0. It does not advance the lane marker or the multiframe counter.
- R9: While reset is asserted, all `lane_vld` bits and all lane data are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A byte is offered this cycle |
| in_sof | input | 1 | The offered byte is byte 0 of a frame |
| in_data | input | 8 | Frame byte |
| lane_data | output | 160 | Lane l byte at bits [8l+7:8l], registered |
| lane_vld | output | 20 | Bit l high when lane l carries a new byte |

## Verification
The bench streams 257 back-to-back short frames with idle gaps. This carries the marker past its 239-to-0 wrap and the multiframe counter past 255. A counter that wraps at 256 instead of 240 would send frame 240's first block to lane 0 of a stale base and write 240 instead of 0 into byte 5. The bench places idle cycles with `in_sof` high between bytes. A design that honoured `in_sof` without `in_valid` would reset its position and misroute the rest of the frame. A restarted partial frame checks that a mid-frame start keeps the marker. A design that advanced it would put block 0 one lane too far. Bytes offered before the first start and after a frame end must strobe no lane.

// File: rtl/rld_pkg.sv
package rld_pkg;

  localparam int BYTE_W = 8;

  // Lane that owns a given block of a frame, computed directly from the
  // marker value rather than from the running lane pointer.
  function automatic int lane_for(input int marker, input int blk, input int lanes);
    return ((marker % lanes) + (blk % lanes)) % lanes;
  endfunction

endpackage

// File: rtl/rld_marker_ctr.sv
module rld_marker_ctr #(
  parameter int LANES    = 20,
  parameter int MARK_CNT = 240,
  parameter int MFAS_W   = 8,
  parameter int MARK_W   = $clog2(MARK_CNT),
  parameter int LANE_W   = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  output logic [MARK_W-1:0] mark,
  output logic [LANE_W-1:0] mark_base,
  output logic [MFAS_W-1:0] mfas
);

  localparam logic [MARK_W-1:0] MARK_LAST = MARK_W'(MARK_CNT - 1);
  localparam logic [LANE_W-1:0] BASE_LAST = LANE_W'(LANES - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mark      <= '0;
      mark_base <= '0;
      mfas      <= '0;
    end else if (adv) begin
      mark      <= (mark == MARK_LAST) ? '0 : mark + 1'b1;
      mark_base <= (mark_base == BASE_LAST) ? '0 : mark_base + 1'b1;
      mfas      <= mfas + 1'b1;
    end
  end

  // R3
  mark_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mark) < MARK_CNT);

  // R3
  mark_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (mark == (($past(mark) == MARK_LAST) ? '0 : $past(mark) + 1'b1)));

  // R5
  mfas_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (mfas == $past(mfas) + 1'b1));

  // R2
  base_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mark_base) == int'(mark) % LANES);

endmodule

// File: rtl/rld_frame_track.sv
module rld_frame_track #(
  parameter int LANES     = 20,
  parameter int BLK_BYTES = 16,
  parameter int FRAME_LEN = 16320,
  parameter int POS_W     = $clog2(FRAME_LEN),
  parameter int LANE_W    = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [LANE_W-1:0] lane_base,
  output logic              acc,
  output logic              in_frame,
  output logic [POS_W-1:0]  cur_pos,
  output logic [LANE_W-1:0] cur_lane,
  output logic              frame_done
);

  localparam int BO_W = (BLK_BYTES > 1) ? $clog2(BLK_BYTES) : 1;
  localparam logic [POS_W-1:0]  LAST_POS  = POS_W'(FRAME_LEN - 1);
  localparam logic [BO_W-1:0]   LAST_BO   = BO_W'(BLK_BYTES - 1);
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  logic              start;
  logic [POS_W-1:0]  pos_q;
  logic [BO_W-1:0]   boff_q;
  logic [BO_W-1:0]   cur_boff;
  logic [LANE_W-1:0] lane_q;

  always_comb begin
    start      = in_valid & in_sof;
    acc        = in_valid & (in_sof | in_frame);
    cur_pos    = start ? '0 : pos_q;
    cur_boff   = start ? '0 : boff_q;
    cur_lane   = start ? lane_base : lane_q;
    frame_done = acc & (cur_pos == LAST_POS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_frame <= 1'b0;
      pos_q    <= '0;
      boff_q   <= '0;
      lane_q   <= '0;
    end else if (acc) begin
      if (frame_done) begin
        in_frame <= 1'b0;
        pos_q    <= '0;
        boff_q   <= '0;
        lane_q   <= '0;
      end else begin
        in_frame <= 1'b1;
        pos_q    <= cur_pos + 1'b1;
        if (cur_boff == LAST_BO) begin
          boff_q <= '0;
          lane_q <= (cur_lane == LAST_LANE) ? '0 : cur_lane + 1'b1;
        end else begin
          boff_q <= cur_boff + 1'b1;
          lane_q <= cur_lane;
        end
      end
    end
  end

  // R7
  first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_frame) |-> in_sof);

endmodule

// File: rtl/rld_oh_insert.sv
module rld_oh_insert #(
  parameter int POS_W    = 14,
  parameter int MARK_W   = 8,
  parameter int MFAS_W   = 8,
  parameter int MARK_POS = 5,
  parameter int MFAS_POS = 6
) (
  input  logic [POS_W-1:0]         cur_pos,
  input  logic [MARK_W-1:0]        mark,
  input  logic [MFAS_W-1:0]        mfas,
  input  logic [rld_pkg::BYTE_W-1:0] in_byte,
  output logic [rld_pkg::BYTE_W-1:0] out_byte
);

  localparam int BW = rld_pkg::BYTE_W;

  always_comb begin
    if (cur_pos == POS_W'(MARK_POS))      out_byte = BW'(mark);
    else if (cur_pos == POS_W'(MFAS_POS)) out_byte = BW'(mfas);
    else                                  out_byte = in_byte;
  end

endmodule

// File: rtl/rld_lane_regs.sv
module rld_lane_regs #(
  parameter int LANES  = 20,
  parameter int LANE_W = $clog2(LANES)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             acc,
  input  logic [LANE_W-1:0]                cur_lane,
  input  logic [rld_pkg::BYTE_W-1:0]       byte_in,
  output logic [LANES*rld_pkg::BYTE_W-1:0] lane_data,
  output logic [LANES-1:0]                 lane_vld
);

  localparam int BW = rld_pkg::BYTE_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic          hit;
    logic          vld_q;
    logic [BW-1:0] data_q;

    assign hit = acc && (cur_lane == LANE_W'(l));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q  <= 1'b0;
        data_q <= '0;
      end else begin
        vld_q <= hit;
        if (hit) data_q <= byte_in;
      end
    end

    assign lane_vld[l]            = vld_q;
    assign lane_data[l*BW +: BW]  = data_q;
  end

  // R1
  one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_vld));

  // R1
  strobe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ($countones(lane_vld) == 1));

endmodule

// File: rtl/rld_lane_distributor.sv
module rld_lane_distributor #(
  parameter int LANES     = 20,
  parameter int BLK_BYTES = 16,
  parameter int FRAME_LEN = 16320,
  parameter int MARK_CNT  = 240,
  parameter int MFAS_W    = 8,
  parameter int MARK_POS  = 5,
  parameter int MFAS_POS  = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic                   in_sof,
  input  logic [7:0]             in_data,
  output logic [LANES*8-1:0]     lane_data,
  output logic [LANES-1:0]       lane_vld
);

  localparam int POS_W  = $clog2(FRAME_LEN);
  localparam int LANE_W = $clog2(LANES);
  localparam int MARK_W = $clog2(MARK_CNT);

  logic              acc;
  logic              in_frame;
  logic              frame_done;
  logic [POS_W-1:0]  cur_pos;
  logic [LANE_W-1:0] cur_lane;
  logic [LANE_W-1:0] mark_base;
  logic [MARK_W-1:0] mark;
  logic [MFAS_W-1:0] mfas;
  logic [7:0]        ins_byte;

  rld_marker_ctr #(
    .LANES(LANES), .MARK_CNT(MARK_CNT), .MFAS_W(MFAS_W),
    .MARK_W(MARK_W), .LANE_W(LANE_W)
  ) u_marker (
    .clk(clk), .rst_n(rst_n), .adv(frame_done),
    .mark(mark), .mark_base(mark_base), .mfas(mfas)
  );

  rld_frame_track #(
    .LANES(LANES), .BLK_BYTES(BLK_BYTES), .FRAME_LEN(FRAME_LEN),
    .POS_W(POS_W), .LANE_W(LANE_W)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .lane_base(mark_base), .acc(acc), .in_frame(in_frame),
    .cur_pos(cur_pos), .cur_lane(cur_lane), .frame_done(frame_done)
  );

  rld_oh_insert #(
    .POS_W(POS_W), .MARK_W(MARK_W), .MFAS_W(MFAS_W),
    .MARK_POS(MARK_POS), .MFAS_POS(MFAS_POS)
  ) u_oh (
    .cur_pos(cur_pos), .mark(mark), .mfas(mfas),
    .in_byte(in_data), .out_byte(ins_byte)
  );

  rld_lane_regs #(
    .LANES(LANES), .LANE_W(LANE_W)
  ) u_lanes (
    .clk(clk), .rst_n(rst_n), .acc(acc), .cur_lane(cur_lane),
    .byte_in(ins_byte), .lane_data(lane_data), .lane_vld(lane_vld)
  );

  // R2
  lane_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> (int'(cur_lane) ==
             rld_pkg::lane_for(int'(mark), int'(cur_pos) / BLK_BYTES, LANES)));

  // R6
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (lane_vld == '0));

  // R8
  restart_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof && in_frame) |=> ($stable(mark) && $stable(mfas)));

endmodule

// File: tb/tb_rld_lane_distributor.sv
module tb_rld_lane_distributor;

  localparam int LANES = 20;
  localparam int BLK   = 16;
  localparam int FLEN  = 320;

  typedef struct packed {
    logic [15:0] f;
    logic [15:0] p;
    logic [7:0]  lane;
    logic        chk_d;
    logic [7:0]  d;
  } vec_t;

  localparam int NT = 18;
  localparam vec_t TBL [NT] = '{
    '{16'd0,   16'd0,   8'd0,  1'b0, 8'd0},
    '{16'd0,   16'd5,   8'd0,  1'b1, 8'd0},
    '{16'd0,   16'd6,   8'd0,  1'b1, 8'd0},
    '{16'd1,   16'd16,  8'd2,  1'b0, 8'd0},
    '{16'd3,   16'd319, 8'd2,  1'b0, 8'd0},
    '{16'd7,   16'd5,   8'd7,  1'b1, 8'd7},
    '{16'd19,  16'd16,  8'd0,  1'b0, 8'd0},
    '{16'd20,  16'd0,   8'd0,  1'b0, 8'd0},
    '{16'd239, 16'd0,   8'd19, 1'b0, 8'd0},
    '{16'd240, 16'd0,   8'd0,  1'b0, 8'd0},
    '{16'd240, 16'd5,   8'd0,  1'b1, 8'd0},
    '{16'd245, 16'd6,   8'd5,  1'b1, 8'd245},
    '{16'd256, 16'd5,   8'd16, 1'b1, 8'd16},
    '{16'd256, 16'd6,   8'd16, 1'b1, 8'd0},
    '{16'd257, 16'd5,   8'd17, 1'b1, 8'd17},
    '{16'd257, 16'd5,   8'd17, 1'b1, 8'd17},
    '{16'd258, 16'd0,   8'd18, 1'b0, 8'd0},
    '{16'd258, 16'd6,   8'd18, 1'b1, 8'd2}
  };

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               in_valid = 1'b0;
  logic               in_sof = 1'b0;
  logic [7:0]         in_data = 8'd0;
  logic [LANES*8-1:0] lane_data;
  logic [LANES-1:0]   lane_vld;

  int vecs = 0;
  int bad = 0;
  int ti = 0;
  int last_lane = -1;
  logic [7:0] last_byte = 8'd0;

  always #10 clk = ~clk;

  rld_lane_distributor #(.LANES(LANES), .BLK_BYTES(BLK), .FRAME_LEN(FLEN)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .lane_data(lane_data), .lane_vld(lane_vld)
  );

  function automatic logic [7:0] pat(input int f, input int p);
    return 8'((p * 7) + (f * 3) + 1);
  endfunction

  task automatic step(input logic v, input logic s, input logic [7:0] d,
                      input int exp_lane, input logic [7:0] exp_byte, input string tag);
    logic [LANES-1:0] ev;
    @(negedge clk);
    in_valid = v;
    in_sof   = s;
    in_data  = d;
    @(posedge clk);
    #5;
    vecs++;
    ev = (exp_lane < 0) ? '0 : (LANES'(1) << exp_lane);
    if (lane_vld !== ev) begin
      bad++;
      $display("FAIL %s: lane_vld got %h expected %h", tag, lane_vld, ev);
    end else if (exp_lane >= 0) begin
      if (lane_data[exp_lane*8 +: 8] !== exp_byte) begin
        bad++;
        $display("FAIL %s: lane %0d data got %h expected %h", tag, exp_lane,
                 lane_data[exp_lane*8 +: 8], exp_byte);
      end
      last_lane = exp_lane;
      last_byte = exp_byte;
    end else if (last_lane >= 0 && lane_data[last_lane*8 +: 8] !== last_byte) begin
      bad++;
      $display("FAIL %s (R6 hold): lane %0d data got %h expected %h", tag, last_lane,
               lane_data[last_lane*8 +: 8], last_byte);
    end
  endtask

  task automatic table_hit(input int f, input int p);
    string tg;
    int    ln;
    if (ti < NT && int'(TBL[ti].f) == f && int'(TBL[ti].p) == p) begin
      tg = (f >= 257) ? "R8 table" : (f >= 239) ? "R3 table" : "R2 table";
      ln = int'(TBL[ti].lane);
      vecs++;
      if (lane_vld[ln] !== 1'b1) begin
        bad++;
        $display("FAIL %s f=%0d p=%0d: lane_vld got %h expected bit %0d", tg, f, p, lane_vld, ln);
      end else if (TBL[ti].chk_d && lane_data[ln*8 +: 8] !== TBL[ti].d) begin
        bad++;
        $display("FAIL %s f=%0d p=%0d: data got %h expected %h", tg, f, p,
                 lane_data[ln*8 +: 8], TBL[ti].d);
      end
      ti++;
    end
  endtask

  // f is the frame count since reset; the marker is f mod 240 and,
  // as 240 is a multiple of 20, the first lane is simply f mod 20.
  task automatic send_frame(input int f, input int n, input bit gaps);
    for (int p = 0; p < n; p++) begin
      logic [7:0] d;
      logic [7:0] eb;
      int         el;
      string      tag;
      if (gaps && (((p * 5) + f) % 37 == 0))
        step(1'b0, 1'b1, 8'hA5, -1, 8'd0, "R6 idle with sof");
      d   = pat(f, p);
      eb  = (p == 5) ? 8'(f % 240) : (p == 6) ? 8'(f % 256) : d;
      el  = (f + (p / BLK)) % LANES;
      tag = (p == 5) ? "R4 marker byte" : (p == 6) ? "R5 multiframe byte" :
            (p < BLK) ? "R1 first block" : "R2 block lane";
      step(1'b1, (p == 0), d, el, eb, tag);
      table_hit(f, p);
    end
  endtask

  task automatic check_reset_state(input string tag);
    vecs++;
    if (lane_vld !== '0 || lane_data !== '0) begin
      bad++;
      $display("FAIL %s: vld=%h data=%h expected all zero", tag, lane_vld, lane_data);
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd >= 200000) begin
        bad++;
        $display("FAIL watchdog: run did not finish, cycles %0d expected below %0d", wd, 200000);
        $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
        $finish;
      end
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    #5;
    check_reset_state("R9 reset");
    @(negedge clk);
    rst_n = 1'b1;

    // R7: bytes before any start of frame are dropped
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'(8'h30 + i), -1, 8'd0, "R7 before first sof");

    // Main stream: 257 frames, carrying both counters across their wraps
    for (int f = 0; f <= 256; f++) send_frame(f, FLEN, 1'b1);

    // R8: partial frame, then a restart that must keep the marker
    send_frame(257, 40, 1'b0);
    send_frame(257, FLEN, 1'b0);
    send_frame(258, FLEN, 1'b0);

    // R7: bytes after a completed frame without a new start are dropped
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 8'(8'h60 + i), -1, 8'd0, "R7 after frame end");

    vecs++;
    if (ti != NT) begin
      bad++;
      $display("FAIL R2 table walk: entries hit %0d expected %0d", ti, NT);
    end

    // R9 and R3/R5 restart: reset in mid-frame
    send_frame(259, 100, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    rst_n    = 1'b0;
    @(posedge clk);
    #5;
    check_reset_state("R9 reset mid-frame");
    @(negedge clk);
    rst_n = 1'b1;
    last_lane = -1;
    // R3, R5: counters back at zero, so frame 0 mapping and overhead return
    send_frame(0, FLEN, 1'b1);
    send_frame(1, FLEN, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule